// File: doc/BRIEF.md
# Outbound Address Translation Window Table

This block turns local addresses that fall inside a fixed local aperture into 64-bit bus addresses. The aperture is cut into equal windows, one window per table entry. Entry 0 serves the first window of the aperture, entry 1 the next one, and so on. Each entry holds a 64-bit target base. A window that is hit adds the in-window offset to its entry's base.

Software uses a single-cycle register port to set the table up:

- a shared window-size code, the log2 of the window size in megabytes;
- a low word and a high word per entry, where bit 0 of the low word enables the entry;
- a command register holding the global translation enable and an unrelated link-training enable, which is kept intact on read-modify-write.

At run time each lookup request gives one registered response one cycle later. The response is a hit flag and the translated address.

Top module: `obwin_xlate`

## Requirements
- R1: After a synchronous reset the command register reads 0, the size register reads 3, every entry word reads 0, and rsp_valid, rsp_hit and link_train_en are 0.
- R2: Register map, with word addresses and reg_addr[1:0] equal to 0:
  - Command register at 0x004. Bit 0 is the link-training enable and bit 1 is the translation enable. All other bits read 0.
  - Size register at 0x010. Bits [2:0] hold the size code and all other bits read 0.
  - Entry n has its low word at 0x200 + 8·n and its high word at 0x204 + 8·n, for n below NUM_WIN.
  - Every other address reads 0 and ignores writes.
- R3: rsp_valid is 1 exactly in the cycle after a cycle with req_valid = 1, and 0 otherwise. rsp_hit is never 1 without rsp_valid.
- R4: The index and offset are taken from off = req_addr − APER_BASE:
  - The window index is off >> (20 + size code).
  - The in-window offset is the low (20 + size code) bits of off.
  - On a hit, rsp_addr = {high word, low word with bit 0 cleared} + in-window offset, as a full 64-bit sum with carry into the high word.
- R5: While command bit 1 is 0, every lookup misses.
- R6: A lookup whose indexed entry has low-word bit 0 equal to 0 misses.
- R7: A lookup misses when req_addr < APER_BASE or when the window index is NUM_WIN or more.
- R8: On a miss, rsp_addr is 0.
- R9: Both command bits are written together. The link_train_en output follows command bit 0 and does not depend on bit 1.
- R10: The size code sets the window size for all entries. With code 4 the windows are 16 MB, and the next lookup already uses the new size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Local address to translate |
| rsp_valid | output | 1 | Lookup response strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation hit |
| rsp_addr | output | 64 | Translated bus address, 0 on a miss |
| link_train_en | output | 1 | Link-training enable held in command bit 0 |

## Verification
Register reads are combinational, so the bench samples reg_rdata in the same cycle it drives the address. A write takes effect at the first rising edge after it is driven. Every lookup is driven at a falling edge and its response is sampled at the next falling edge, which is exactly one rising edge later. The bench checks one further cycle to confirm that rsp_valid has dropped. Because of this timing, a size-code or enable change written just before a lookup must already show in that lookup's response.

// File: rtl/obwin_pkg.sv
package obwin_pkg;

    localparam int REG_AW   = 12;
    localparam int MB_SHIFT = 20;

    localparam logic [REG_AW-1:0] OFS_CMD  = 12'h004;
    localparam logic [REG_AW-1:0] OFS_SIZE = 12'h010;

    localparam logic [2:0] SIZE_RST = 3'd3;

    // command register fields: bit 1 translation enable, bit 0 link training
    typedef struct packed {
        logic xlat_en;
        logic train_en;
    } cmd_t;

    typedef struct packed {
        logic [31:0] hi;
        logic [31:0] lo;
    } win_entry_t;

    typedef struct packed {
        logic        hit;
        logic [63:0] addr;
    } xlat_rsp_t;

    function automatic logic [5:0] win_shift(input logic [2:0] code);
        return 6'(MB_SHIFT) + {3'b000, code};
    endfunction

endpackage

// File: rtl/obwin_regs.sv
module obwin_regs
    import obwin_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [REG_AW-1:0]         addr,
    input  logic [31:0]               wdata,
    output logic [31:0]               rdata,
    output cmd_t                      cmd,
    output logic [2:0]                size_code,
    output win_entry_t [NUM_WIN-1:0]  entries
);

    localparam int         IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam logic [6:0] NW = 7'(NUM_WIN);

    logic          hit_cmd, hit_size, hit_win;
    logic [IW-1:0] widx;
    win_entry_t    ent_q [NUM_WIN];

    assign hit_cmd  = (addr == OFS_CMD);
    assign hit_size = (addr == OFS_SIZE);
    assign hit_win  = (addr[11:9] == 3'b001) && (addr[1:0] == 2'b00) &&
                      ({1'b0, addr[8:3]} < NW);
    assign widx     = addr[3 +: IW];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd       <= '0;
            size_code <= SIZE_RST;
        end else if (we) begin
            if (hit_cmd)  cmd       <= cmd_t'(wdata[1:0]);
            if (hit_size) size_code <= wdata[2:0];
        end
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else if (we && hit_win && (widx == IW'(g))) begin
                if (addr[2]) ent_q[g].hi <= wdata;
                else         ent_q[g].lo <= wdata;
            end
        end
        assign entries[g] = ent_q[g];
    end

    always_comb begin
        rdata = '0;
        if (hit_cmd)       rdata = {30'd0, cmd};
        else if (hit_size) rdata = {29'd0, size_code};
        else if (hit_win)  rdata = addr[2] ? ent_q[widx].hi : ent_q[widx].lo;
    end

    // R2: a command write lands both bits on the next cycle
    p_cmd_write_r2: assert property (@(posedge clk) disable iff (rst)
        (we && hit_cmd) |=> (cmd == cmd_t'($past(wdata[1:0]))));

    // R10: the size code only moves on a write to its own address
    p_size_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(we && hit_size) |=> $stable(size_code));

endmodule

// File: rtl/obwin_lookup.sv
module obwin_lookup
    import obwin_pkg::*;
#(
    parameter int                 NUM_WIN   = 8,
    parameter int                 LADDR_W   = 32,
    parameter logic [LADDR_W-1:0] APER_BASE = 32'h4000_0000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [LADDR_W-1:0]        req_addr,
    input  logic                      xlat_en,
    input  logic [2:0]                size_code,
    input  win_entry_t [NUM_WIN-1:0]  entries,
    output logic                      rsp_valid,
    output xlat_rsp_t                 rsp
);

    localparam int IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic               below, in_range, hit;
    logic [5:0]         shift;
    logic [LADDR_W-1:0] offset, idx_full, inwin;
    win_entry_t         sel;
    logic [63:0]        xaddr;

    always_comb begin
        below    = (req_addr < APER_BASE);
        offset   = req_addr - APER_BASE;
        shift    = win_shift(size_code);
        idx_full = offset >> shift;
        inwin    = offset & ~({LADDR_W{1'b1}} << shift);
        in_range = !below && (idx_full < LADDR_W'(NUM_WIN));
        sel      = entries[idx_full[IW-1:0]];
        hit      = xlat_en && in_range && sel.lo[0];
        xaddr    = ({sel.hi, sel.lo} & ~64'd1) + {{(64-LADDR_W){1'b0}}, inwin};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp       <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp.hit   <= req_valid && hit;
            rsp.addr  <= (req_valid && hit) ? xaddr : 64'd0;
        end
    end

    // R3: response strobe follows the request by one cycle
    p_valid_follows_req_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_no_spurious_valid_r3: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    p_hit_needs_valid_r3: assert property (@(posedge clk) disable iff (rst)
        rsp.hit |-> rsp_valid);

    // R5: global disable forces a miss
    p_disabled_miss_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !xlat_en) |=> !rsp.hit);

    // R7: addresses below the aperture never hit
    p_below_miss_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_addr < APER_BASE)) |=> !rsp.hit);

    // R8: a miss carries a zero address
    p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp.hit) |-> (rsp.addr == 64'd0));

endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
    import obwin_pkg::*;
#(
    parameter int           NUM_WIN   = 8,
    parameter logic [31:0]  APER_BASE = 32'h4000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic [63:0] rsp_addr,
    output logic        link_train_en
);

    cmd_t                     cmd;
    logic [2:0]               size_code;
    win_entry_t [NUM_WIN-1:0] entries;
    xlat_rsp_t                rsp;

    obwin_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .cmd       (cmd),
        .size_code (size_code),
        .entries   (entries)
    );

    obwin_lookup #(
        .NUM_WIN   (NUM_WIN),
        .LADDR_W   (32),
        .APER_BASE (APER_BASE)
    ) u_lookup (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .xlat_en   (cmd.xlat_en),
        .size_code (size_code),
        .entries   (entries),
        .rsp_valid (rsp_valid),
        .rsp       (rsp)
    );

    assign rsp_hit       = rsp.hit;
    assign rsp_addr      = rsp.addr;
    assign link_train_en = cmd.train_en;

endmodule

// File: tb/sim_obwin_xlate.sv
module sim_obwin_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, link_train_en;
    logic [63:0] rsp_addr;

    int n_chk = 0;
    int n_bad = 0;

    // bench copy of what software programmed
    logic [31:0] m_lo [8];
    logic [31:0] m_hi [8];
    logic        m_xen = 1'b0;
    logic [2:0]  m_code = 3'd3;

    localparam logic [31:0] BASE = 32'h4000_0000;

    localparam logic [31:0] VEC_ADDR [10] = '{
        32'h4000_0000, 32'h4000_1234, 32'h407F_FFFF, 32'h4080_0000, 32'h42A0_0010,
        32'h43FF_FFFF, 32'h4400_0000, 32'h3FFF_FFFF, 32'h41D0_0000, 32'h4200_0004
    };
    localparam logic VEC_HIT [10] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0,
                                      1'b1, 1'b0, 1'b0, 1'b1, 1'b1};

    obwin_xlate u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_addr(rsp_addr), .link_train_en(link_train_en)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic lookup(input logic [31:0] la);
        @(negedge clk);
        req_valid = 1'b1; req_addr = la;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [64:0] model(input logic [31:0] la);
        logic [31:0] off, idx, inw;
        logic [5:0]  sh;
        if (la < BASE || !m_xen) return '0;
        off = la - BASE;
        sh  = 6'd20 + {3'd0, m_code};
        idx = off >> sh;
        inw = off & ~(32'hFFFF_FFFF << sh);
        if (idx >= 32'd8) return '0;
        if (!m_lo[idx[2:0]][0]) return '0;
        return {1'b1, ({m_hi[idx[2:0]], m_lo[idx[2:0]]} & ~64'd1) + {32'd0, inw}};
    endfunction

    task automatic lookup_chk(input string tag, input logic [31:0] la);
        logic [64:0] e;
        e = model(la);
        lookup(la);
        check({tag, " valid"}, {63'd0, rsp_valid}, 64'd1);
        check({tag, " hit"},   {63'd0, rsp_hit},   {63'd0, e[64]});
        check({tag, " addr"},  rsp_addr,           e[63:0]);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(12'h004, d); check("R1 cmd", {32'd0, d}, 64'd0);
        rd(12'h010, d); check("R1 size", {32'd0, d}, 64'd3);
        rd(12'h200, d); check("R1 entry0 lo", {32'd0, d}, 64'd0);
        rd(12'h23C, d); check("R1 entry7 hi", {32'd0, d}, 64'd0);
        check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R1 train", {63'd0, link_train_en}, 64'd0);

        for (int i = 0; i < 8; i++) begin
            m_lo[i] = 32'h4000_0000 + 32'(i) * 32'h0080_0000 + ((i == 5) ? 32'd0 : 32'd1);
            m_hi[i] = 32'h10 + 32'(i);
        end
        m_lo[3] = 32'hFFC0_0001;
        for (int i = 0; i < 8; i++) begin
            wr(12'h200 + 12'(8 * i), m_lo[i]);
            wr(12'h204 + 12'(8 * i), m_hi[i]);
        end

        // R5 / R8: global disable gives a miss with zero address
        lookup_chk("R5 global off", 32'h4000_0000);
        check("R8 miss addr", rsp_addr, 64'd0);

        // R9: both command bits set
        wr(12'h004, 32'h3); m_xen = 1'b1;
        rd(12'h004, d); check("R9 cmd readback", {32'd0, d}, 64'd3);
        check("R9 train on", {63'd0, link_train_en}, 64'd1);

        // table walk: R4, R6, R7
        for (int v = 0; v < 10; v++) begin
            lookup_chk($sformatf("R4 R6 R7 vec%0d", v), VEC_ADDR[v]);
            check($sformatf("R4 vec%0d table hit", v), {63'd0, rsp_hit}, {63'd0, VEC_HIT[v]});
        end

        // R4 carry into high word, literal value
        lookup(32'h41D0_0000);
        check("R4 carry", rsp_addr, 64'h0000_0014_0010_0000);
        @(negedge clk);
        check("R3 valid drops", {63'd0, rsp_valid}, 64'd0);

        // R2 / R9: only bits [1:0] stored, train cleared, xlat kept
        wr(12'h004, 32'hFFFF_FFFE);
        rd(12'h004, d); check("R2 cmd mask", {32'd0, d}, 64'd2);
        check("R9 train off", {63'd0, link_train_en}, 64'd0);
        lookup_chk("R9 xlat kept", 32'h4080_0010);

        // R2 readback and unmapped addresses
        rd(12'h218, d); check("R2 entry3 lo", {32'd0, d}, 64'hFFC0_0001);
        rd(12'h22C, d); check("R2 entry5 hi", {32'd0, d}, 64'h15);
        rd(12'h300, d); check("R2 beyond table", {32'd0, d}, 64'd0);
        rd(12'h00C, d); check("R2 unmapped", {32'd0, d}, 64'd0);
        wr(12'h240, 32'h1234_5679);
        rd(12'h240, d); check("R2 write ignored", {32'd0, d}, 64'd0);

        // R10: 16 MB windows
        wr(12'h010, 32'h4); m_code = 3'd4;
        lookup_chk("R10 code4 idx1", 32'h4180_0000);
        check("R10 code4 literal", rsp_addr, 64'h0000_0011_4100_0000);
        lookup_chk("R10 code4 idx7", 32'h47FF_FFFF);
        lookup_chk("R7 code4 past end", 32'h4800_0000);
        wr(12'h010, 32'hFFFF_FFF9); m_code = 3'd1;
        rd(12'h010, d); check("R2 size mask", {32'd0, d}, 64'd1);
        lookup_chk("R10 code1", 32'h4030_0000);

        // R6: disable entry 0
        wr(12'h200, 32'h4000_0000); m_lo[0] = 32'h4000_0000;
        lookup_chk("R6 entry off", 32'h4000_0100);
        check("R6 miss", {63'd0, rsp_hit}, 64'd0);

        // R5: global disable again
        wr(12'h004, 32'h1); m_xen = 1'b0;
        lookup_chk("R5 disabled", 32'h4020_0000);
        check("R5 miss", {63'd0, rsp_hit}, 64'd0);

        // R1: reset again clears the table
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(12'h208, d); check("R1 reset entry1", {32'd0, d}, 64'd0);
        rd(12'h010, d); check("R1 reset size", {32'd0, d}, 64'd3);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule